// File: doc/BRIEF.md
# CPU Island Power-Up Sequencer

This block brings one of two secondary processor power islands out of power-down and then lets that processor leave reset. A one-cycle start pulse, together with a one-bit CPU select, launches the bring-up. Each island has its own 32-bit power control word, and those words drive the power switches. The switches answer on a 32-bit status word for each island. The sequencer sets or clears one group of control bits at a time. After each power-raising step it holds until the matching status bits come back before it moves on.

Clamps and the memory array power-down field are released only once the supply they protect reports good. The active-low reset bit of the chosen CPU is raised only after every earlier step has finished. A control value is never rolled back: each step adds to the bits already set by the steps before it. Every wait is bounded by a cycle limit that software supplies. If a wait runs out, the sequencer stops where it is, raises error and leaves the processor held in reset.

Top module: `cpu_island_powerup`

## Requirements
- R1: After reset, both power words read 0x0000_8F04 (logic clamp bit 15 set, array power-down field bits 11:8 all ones, memory clamp bit 2 set, all power-on and power-good bits clear), `cpu_rst_ctrl` reads 0, and busy, done and error are low.
- R2: If the selected CPU's reset bit (bit 13 + CPU index of `cpu_rst_ctrl`) is already 1 at start, no power bit changes and done pulses in the cycle after start.
- R3: The first step sets logic power-on bits 21:20 to 2'b11 and holds until status bits 29:28 both read 1.
- R4: Logic power-good bits 17:16 are set only after logic power-on has completed, and the sequencer then holds until status bits 25:24 both read 1.
- R5: After logic power-good, the logic clamp (bit 15) is cleared and then the array power-down field (bits 11:8) is cleared, with no status wait for either.
- R6: Memory power-on (bit 1) is set and the sequencer holds for status bit 5. Memory power-good (bit 0) is then set and the sequencer holds for status bit 4. The memory clamp (bit 2) is cleared after that.
- R7: Only as the last step does the CPU's reset bit rise, and at that point the power word reads 0x0033_0003.
- R8: If a wait sees no matching status for `tmo_limit`+1 cycles, the sequencer enters a failed state. In that state error stays high, busy is low, and the power words and the reset word hold their values. A later start retries the sequence.
- R9: A start pulse that arrives while busy is high is ignored.
- R10: The power word of the CPU that was not selected is never changed.
- R11: done is a one-cycle pulse at the end of a run, busy is high from the cycle after start until then, and busy and done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to bring up a CPU |
| cpu_sel | input | 1 | Index of the CPU to bring up |
| tmo_limit | input | TMO_W | Cycle limit for each status wait |
| pwr_stat | input | 64 | Switch status words, CPU i at bits 32i+31:32i |
| pwr_ctrl | output | 64 | Power control words, CPU i at bits 32i+31:32i |
| cpu_rst_ctrl | output | 32 | Control word holding active-low CPU reset bits 13 and 14 |
| busy | output | 1 | A bring-up is in progress |
| done | output | 1 | One-cycle pulse when a run finishes or is skipped |
| error | output | 1 | A status wait ran out of time |

## Verification
An error in the step order shows up in the power word within one cycle. For example, a clamp that clears before its supply reports good, or a power-good bit that is set before power-on completes, appears in the word right away, and the checker reports it at that edge. A wrong count in the timeout counter moves the cycle in which error rises. The stage sweep therefore measures that cycle exactly and also compares the frozen word against a value built up step by step. A select that is latched wrongly, or a lost skip test, shows up as a change in the other CPU's word or as an extra reset bit once the run has ended.

// File: rtl/pup_pkg.sv
// Package: shared state encoding and bit positions for the island power-up
// sequencer. Assumes 32-bit control and status words.
package pup_pkg;
    localparam int WORD_W      = 32;
    localparam int NCPU        = 2;
    localparam int RST_BIT_LO  = 13;
    localparam int LON_LO      = 20;
    localparam int LON_ST_LO   = 28;
    localparam int LGOOD_LO    = 16;
    localparam int LGOOD_ST_LO = 24;
    localparam int LCLAMP_BIT  = 15;
    localparam int PDA_LO      = 8;
    localparam int PDA_W       = 4;
    localparam int MON_BIT     = 1;
    localparam int MON_ST_BIT  = 5;
    localparam int MGOOD_BIT   = 0;
    localparam int MGOOD_ST_BIT = 4;
    localparam int MCLAMP_BIT  = 2;
    localparam logic [WORD_W-1:0] PWR_RESET_WORD = 32'h0000_8F04;

    typedef enum logic [3:0] {
        ST_IDLE, ST_LON, ST_LGOOD, ST_LCLAMP, ST_MPDA, ST_MON,
        ST_MGOOD, ST_MCLAMP, ST_RELEASE, ST_FINISH, ST_FAIL
    } pup_state_e;
endpackage

// File: rtl/pup_timer.sv
// Wait timer: counts cycles spent in one status wait and flags when the
// count equals the limit. Assumes the owner clears it outside waits.
module pup_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    localparam logic [TMO_W-1:0] CNT_MAX = '1;
    logic [TMO_W-1:0] cnt;

    // Saturating cycle counter, restarted by clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == limit);
endmodule

// File: rtl/pup_fsm.sv
// Step sequencer: accepts a start, tests the skip condition, walks the
// power steps and holds each wait until the status matches or the timer runs
// out. Assumes the selected status word is presented on stat.
module pup_fsm
    import pup_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cpu_sel,
    input  logic [NCPU-1:0]   rst_bits,
    input  logic [WORD_W-1:0] stat,
    input  logic              expired,
    output pup_state_e        state,
    output logic              sel,
    output logic              tmo_clear
);
    pup_state_e nxt;
    logic       wait_st;
    logic       matched;

    // Status match for whichever wait step is active.
    always_comb begin
        wait_st = 1'b1;
        matched = 1'b0;
        case (state)
            ST_LON:   matched = (stat[LON_ST_LO +: 2] == 2'b11);
            ST_LGOOD: matched = (stat[LGOOD_ST_LO +: 2] == 2'b11);
            ST_MON:   matched = stat[MON_ST_BIT];
            ST_MGOOD: matched = stat[MGOOD_ST_BIT];
            default:  wait_st = 1'b0;
        endcase
        tmo_clear = !wait_st || matched;
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE, ST_FINISH, ST_FAIL: begin
                if (start)
                    nxt = rst_bits[cpu_sel] ? ST_FINISH : ST_LON;
                else if (state == ST_FINISH)
                    nxt = ST_IDLE;
            end
            ST_LON:     nxt = matched ? ST_LGOOD : (expired ? ST_FAIL : ST_LON);
            ST_LGOOD:   nxt = matched ? ST_LCLAMP : (expired ? ST_FAIL : ST_LGOOD);
            ST_LCLAMP:  nxt = ST_MPDA;
            ST_MPDA:    nxt = ST_MON;
            ST_MON:     nxt = matched ? ST_MGOOD : (expired ? ST_FAIL : ST_MON);
            ST_MGOOD:   nxt = matched ? ST_MCLAMP : (expired ? ST_FAIL : ST_MGOOD);
            ST_MCLAMP:  nxt = ST_RELEASE;
            ST_RELEASE: nxt = ST_FINISH;
            default:    nxt = ST_IDLE;
        endcase
    end

    // State and CPU select registers; select is latched on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel   <= 1'b0;
        end else begin
            state <= nxt;
            if ((state == ST_IDLE || state == ST_FINISH || state == ST_FAIL) && start)
                sel <= cpu_sel;
        end
    end
endmodule

// File: rtl/pup_word.sv
// Power control word of one island: applies the action of the current step
// while this island is the selected one. Bits only accumulate.
module pup_word
    import pup_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  pup_state_e        state,
    output logic [WORD_W-1:0] word
);
    // Per-step set or clear of the control groups.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word <= PWR_RESET_WORD;
        else if (act) begin
            case (state)
                ST_LON:    word[LON_LO +: 2]   <= 2'b11;
                ST_LGOOD:  word[LGOOD_LO +: 2] <= 2'b11;
                ST_LCLAMP: word[LCLAMP_BIT]    <= 1'b0;
                ST_MPDA:   word[PDA_LO +: PDA_W] <= '0;
                ST_MON:    word[MON_BIT]       <= 1'b1;
                ST_MGOOD:  word[MGOOD_BIT]     <= 1'b1;
                ST_MCLAMP: word[MCLAMP_BIT]    <= 1'b0;
                default:   word <= word;
            endcase
        end
    end
endmodule

// File: rtl/cpu_island_powerup.sv
// Top: one sequencer, one wait timer, one power word per island, and the
// shared reset control word. Assumes at most two secondary CPUs.
module cpu_island_powerup
    import pup_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   cpu_sel,
    input  logic [TMO_W-1:0]       tmo_limit,
    input  logic [NCPU*WORD_W-1:0] pwr_stat,
    output logic [NCPU*WORD_W-1:0] pwr_ctrl,
    output logic [WORD_W-1:0]      cpu_rst_ctrl,
    output logic                   busy,
    output logic                   done,
    output logic                   error
);
    pup_state_e        state;
    logic              sel;
    logic              tmo_clear;
    logic              expired;
    logic [WORD_W-1:0] stat_sel;

    assign stat_sel = pwr_stat[sel*WORD_W +: WORD_W];

    pup_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .cpu_sel(cpu_sel),
        .rst_bits(cpu_rst_ctrl[RST_BIT_LO +: NCPU]), .stat(stat_sel),
        .expired(expired), .state(state), .sel(sel), .tmo_clear(tmo_clear)
    );

    pup_timer #(.TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(tmo_clear),
        .limit(tmo_limit), .expired(expired)
    );

    for (genvar i = 0; i < NCPU; i++) begin : g_island
        pup_word u_word (
            .clk(clk), .rst_n(rst_n), .act(sel == 1'(i)), .state(state),
            .word(pwr_ctrl[i*WORD_W +: WORD_W])
        );
    end

    // Reset control word: the selected CPU's bit rises in the release step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cpu_rst_ctrl <= '0;
        else if (state == ST_RELEASE)
            cpu_rst_ctrl[RST_BIT_LO + int'(sel)] <= 1'b1;
    end

    assign busy  = !(state == ST_IDLE || state == ST_FINISH || state == ST_FAIL);
    assign done  = (state == ST_FINISH);
    assign error = (state == ST_FAIL);
endmodule

// File: rtl/pup_checker.sv
// Checker: ordering and status properties of the power-up sequencer, bound
// to the top module. Observes ports only.
module pup_checker #(
    parameter int TMO_W = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [63:0] pwr_ctrl,
    input logic [31:0] cpu_rst_ctrl,
    input logic        busy,
    input logic        done,
    input logic        error
);
    // R4: power-good is never set while logic power-on is incomplete
    p_good_after_on_r4_c0: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ctrl[17:16] != 2'b00) |-> (pwr_ctrl[21:20] == 2'b11));
    p_good_after_on_r4_c1: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ctrl[49:48] != 2'b00) |-> (pwr_ctrl[53:52] == 2'b11));
    // R5: clamp released only with logic power good
    p_clamp_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ctrl[15] |-> (pwr_ctrl[17:16] == 2'b11));
    // R6: memory power-good only after memory power-on
    p_mem_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_ctrl[0] |-> pwr_ctrl[1]);
    // R7: reset release only with a fully powered island
    p_release_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_ctrl[13]) |-> (pwr_ctrl[31:0] == 32'h0033_0003));
    p_release_last_r7_c1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_ctrl[14]) |-> (pwr_ctrl[63:32] == 32'h0033_0003));
    // R8: failed state freezes all control
    p_fail_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> (error && $stable(pwr_ctrl) && $stable(cpu_rst_ctrl)));
    // R11: done is a single pulse and exclusive with busy
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);
    p_busy_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
endmodule

bind cpu_island_powerup pup_checker #(.TMO_W(TMO_W)) u_pup_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .pwr_ctrl(pwr_ctrl),
    .cpu_rst_ctrl(cpu_rst_ctrl), .busy(busy), .done(done), .error(error)
);

// File: tb/test_cpu_island_powerup.sv
module test_cpu_island_powerup;
    localparam int CLK_P = 10;
    localparam int TMO_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             cpu_sel = 1'b0;
    logic [TMO_W-1:0] tmo_limit = 8'd8;
    logic [63:0]      pwr_stat;
    logic [63:0]      pwr_ctrl;
    logic [31:0]      cpu_rst_ctrl;
    logic             busy, done, error;
    logic [3:0]       stuck = 4'b0;
    int               n_chk = 0;
    int               n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    cpu_island_powerup #(.TMO_W(TMO_W)) i_cpu_island_powerup (
        .clk(clk), .rst_n(rst_n), .start(start), .cpu_sel(cpu_sel),
        .tmo_limit(tmo_limit), .pwr_stat(pwr_stat), .pwr_ctrl(pwr_ctrl),
        .cpu_rst_ctrl(cpu_rst_ctrl), .busy(busy), .done(done), .error(error)
    );

    // Switch model: status follows control one cycle later unless stuck
    // (stuck[0] logic on, [1] logic good, [2] memory on, [3] memory good).
    always_ff @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            pwr_stat[i*32 +: 32] <= '0;
            pwr_stat[i*32+28 +: 2] <= stuck[0] ? 2'b00 : pwr_ctrl[i*32+20 +: 2];
            pwr_stat[i*32+24 +: 2] <= stuck[1] ? 2'b00 : pwr_ctrl[i*32+16 +: 2];
            pwr_stat[i*32+5]       <= stuck[2] ? 1'b0 : pwr_ctrl[i*32+1];
            pwr_stat[i*32+4]       <= stuck[3] ? 1'b0 : pwr_ctrl[i*32+0];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; stuck = 4'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_start(input logic c);
        @(negedge clk); start = 1'b1; cpu_sel = c;
        @(negedge clk); start = 1'b0;
    endtask

    // Waits at negedges until done or error; returns 1 if done was seen.
    task automatic wait_end(output logic saw_done);
        saw_done = 1'b0;
        for (int k = 0; k < 300; k++) begin
            if (done) begin saw_done = 1'b1; break; end
            if (error) break;
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] stage_word(input int stage);
        case (stage)
            0: return 32'h0030_8F04;
            1: return 32'h0033_8F04;
            2: return 32'h0033_0006;
            default: return 32'h0033_0007;
        endcase
    endfunction

    initial begin
        #(CLK_P * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic sd;
        int   n;
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 word0", pwr_ctrl[31:0], 32'h0000_8F04);
        chk("R1 word1", pwr_ctrl[63:32], 32'h0000_8F04);
        chk("R1 rst word", cpu_rst_ctrl, 32'h0);
        chk("R1 flags", {29'b0, busy, done, error}, 32'h0);

        // R3 R5 R6 R7 R10 R11 full bring-up for each CPU
        for (int c = 0; c < 2; c++) begin
            do_reset();
            pulse_start(c[0]);
            chk("R11 busy after start", {31'b0, busy}, 32'h1);
            wait_end(sd);
            chk("R11 done pulse", {31'b0, sd}, 32'h1);
            chk("R11 busy with done", {31'b0, busy}, 32'h0);
            chk("R7 reset bit", cpu_rst_ctrl, 32'h1 << (13 + c));
            chk("R3 R5 R6 final word", pwr_ctrl[c*32 +: 32], 32'h0033_0003);
            chk("R10 other word", pwr_ctrl[(1-c)*32 +: 32], 32'h0000_8F04);
            @(negedge clk);
            chk("R11 done single", {31'b0, done}, 32'h0);
            // R2 skip when already released
            pulse_start(c[0]);
            chk("R2 skip done", {31'b0, done}, 32'h1);
            chk("R2 skip word", pwr_ctrl[c*32 +: 32], 32'h0033_0003);
            chk("R2 skip rst", cpu_rst_ctrl, 32'h1 << (13 + c));
        end

        // R9 start ignored while busy
        do_reset();
        pulse_start(1'b1);
        @(negedge clk); start = 1'b1; cpu_sel = 1'b0;
        @(negedge clk); start = 1'b0;
        wait_end(sd);
        repeat (3) @(negedge clk);
        chk("R9 only cpu1 released", cpu_rst_ctrl, 32'h0000_4000);
        chk("R9 cpu0 untouched", pwr_ctrl[31:0], 32'h0000_8F04);

        // R8 exact timeout cycle, stuck on logic power-on
        for (int lim = 0; lim < 6; lim++) begin
            do_reset();
            stuck = 4'b0001; tmo_limit = 8'(lim);
            @(negedge clk); start = 1'b1; cpu_sel = 1'b1;
            n = 0;
            for (int k = 0; k < 50; k++) begin
                @(posedge clk); n++;
                @(negedge clk); start = 1'b0;
                if (error) break;
            end
            chk("R8 timeout cycle", 32'(n), 32'(lim + 2));
        end

        // R8 failure at every wait stage, both CPUs, then retry
        for (int c = 0; c < 2; c++) begin
            for (int st = 0; st < 4; st++) begin
                do_reset();
                stuck = 4'b1 << st; tmo_limit = 8'd4;
                pulse_start(c[0]);
                wait_end(sd);
                chk("R8 error raised", {30'b0, error, busy}, 32'h2);
                chk("R8 frozen word", pwr_ctrl[c*32 +: 32], stage_word(st));
                repeat (5) @(negedge clk);
                chk("R8 still frozen", pwr_ctrl[c*32 +: 32], stage_word(st));
                chk("R8 no release", cpu_rst_ctrl, 32'h0);
                chk("R10 other word", pwr_ctrl[(1-c)*32 +: 32], 32'h0000_8F04);
                stuck = 4'b0;
                pulse_start(c[0]);
                wait_end(sd);
                chk("R8 retry completes", cpu_rst_ctrl, 32'h1 << (13 + c));
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule